// File: doc/BRIEF.md
# Dual-Stack Forth Processor Core

A 16-bit processor core that executes Forth words directly. It has no register file and no condition flags. All computation works on the top of a data stack, held in a register (T), and on the entry beneath it (N). A second hardware stack holds return addresses and values that a program moves there. Every instruction completes in one clock cycle.

The core fetches 16-bit instruction words through a 13-bit program counter. It reads and writes a word-addressed data space. In that space, address bit 13 selects between RAM and a memory-mapped I/O region. A store to the I/O region raises a write strobe for one cycle instead of writing RAM. The tops of both stacks are brought out so that the surrounding logic can see them.

One ALU instruction word carries independent fields for the following:
- the ALU function;
- a copy of T into N;
- a push of T onto the return stack;
- a return;
- a store;
- a signed step of each stack pointer.

A single instruction can therefore perform a whole Forth word, such as a store, a return or a move between the two stacks.

Top module: `stack_cpu`

## Requirements
- R1: While reset is asserted and right after it is released, the program counter, T and both stack pointers are zero. Executing a depth instruction (ALU op 14, T-to-N set, data delta +1) as the first instruction therefore returns 0.
- R2: An instruction with bit 15 set pushes the following onto the data stack: its bits 14..0, zero-extended to 16 bits. The old T becomes N.
- R3: An instruction whose bits 15..13 are 000 loads the program counter from bits 12..0. The stacks are left unchanged.
- R4: When bits 15..13 are 001, the core pops the data stack, so N becomes T. The program counter is loaded from bits 12..0 only if the popped T was zero. Otherwise it advances by one.
- R5: When bits 15..13 are 010, the core pushes the call address plus one, zero-extended, onto the return stack. It then loads the program counter from bits 12..0.
- R6: When bits 15..13 are 011, the ALU fields are laid out as follows:
  - bit 12: load the PC from the return-stack top;
  - bits 11..8: ALU op;
  - bit 7: copy the old T into the new N slot;
  - bit 6: copy T onto the return stack;
  - bit 5: store N at address T;
  - bits 3..2: return-stack delta;
  - bits 1..0: data-stack delta.

  A delta of 01 means +1, 11 means -1 and 00 means none.
- R7: The ALU op codes are as follows. T is replaced by the result.

  | Code | Result |
  |------|--------|
  | 0 | T |
  | 1 | N |
  | 2 | T+N |
  | 3 | T&N |
  | 4 | T\|N |
  | 5 | T^N |
  | 6 | ~T |
  | 10 | T-1 |
  | 11 | return-stack top |
  | 12 | data word at address T |
- R8: Op 7 (N==T), op 8 (N<T, signed) and op 15 (N<T, unsigned) return 16'hFFFF when true and 0 when false.
- R9: Op 9 is N shifted right by T[3:0] and op 13 is N shifted left by T[3:0], both filling with zeros. Op 14 returns the return pointer in bits 15..8 and the data pointer in bits 7..0, each zero-extended.
- R10: A store writes N into RAM word T[12:0] when T[13] is 0. When T[13] is 1 it raises io_we_o for exactly that one cycle and leaves RAM unchanged. Op 12 reads RAM when T[13] is 0 and the I/O read data when T[13] is 1.
- R11: An ALU instruction with bit 12 set and a return delta of -1 returns. The program counter is loaded from the return-stack top, and that entry is popped.
- R12: Both stack pointers are 5 bits wide and wrap modulo 32 on overflow and underflow, with no trap. After 32 pushes from reset, the data pointer reads 0. After one pop of each stack from reset, the depth value reads 16'h1F1F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_o | output | 13 | Instruction fetch address |
| insn_i | input | 16 | Instruction word at pc_o, same cycle |
| addr_o | output | 13 | Data word address (T[12:0]) |
| wdata_o | output | 16 | Store data (N) |
| mem_we_o | output | 1 | RAM write enable |
| mem_rdata_i | input | 16 | RAM read data at addr_o, same cycle |
| io_we_o | output | 1 | I/O write strobe |
| io_rdata_i | input | 16 | I/O read data at addr_o, same cycle |
| tos_o | output | 16 | Data stack top T |
| nos_o | output | 16 | Data stack second entry N |
| rtos_o | output | 16 | Return stack top |

## Verification
Pointer wraparound is the hardest condition to reach from the ports. The stack memories are not visible, and a wrap shows only through the depth word or through which entry later comes back as N. The bench reaches an overflow with a program of 32 back-to-back literals. It reaches an underflow by popping each stack directly out of reset. It then reads the depth word, and on overflow also reads the N that came back, as the observed values. Conditional branches are run with both a zero and a nonzero operand, so that the popped stack and the fall-through path are compared separately.

// File: rtl/stack_cpu_pkg.sv
package stack_cpu_pkg;

  localparam int unsigned XLEN = 16;
  localparam int unsigned PCW  = 13;

  typedef enum logic [3:0] {
    OP_T     = 4'd0,
    OP_N     = 4'd1,
    OP_ADD   = 4'd2,
    OP_AND   = 4'd3,
    OP_OR    = 4'd4,
    OP_XOR   = 4'd5,
    OP_INV   = 4'd6,
    OP_EQ    = 4'd7,
    OP_LTS   = 4'd8,
    OP_SHR   = 4'd9,
    OP_DEC   = 4'd10,
    OP_R     = 4'd11,
    OP_LD    = 4'd12,
    OP_SHL   = 4'd13,
    OP_DEPTH = 4'd14,
    OP_LTU   = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic       r2pc;
    alu_op_e    op;
    logic       t2n;
    logic       t2r;
    logic       st;
    logic       rsvd;
    logic [1:0] rd;
    logic [1:0] dd;
  } alu_fld_t;

  typedef enum logic [1:0] {
    TS_KEEP = 2'd0,
    TS_LIT  = 2'd1,
    TS_N    = 2'd2,
    TS_ALU  = 2'd3
  } t_src_e;

  typedef enum logic [1:0] {
    PS_INC = 2'd0,
    PS_TGT = 2'd1,
    PS_CBR = 2'd2,
    PS_RET = 2'd3
  } pc_src_e;

  typedef struct packed {
    t_src_e     t_src;
    pc_src_e    pc_src;
    alu_op_e    op;
    logic [1:0] dd;
    logic [1:0] rd;
    logic       ds_we;
    logic       rs_we;
    logic       rs_link;
    logic       st;
  } ctrl_t;

endpackage

// File: rtl/stack_cpu_decode.sv
module stack_cpu_decode
  import stack_cpu_pkg::*;
(
  input  logic [XLEN-1:0] insn_i,
  output ctrl_t           ctrl_o
);

  alu_fld_t fld;
  assign fld = alu_fld_t'(insn_i[12:0]);

  logic unused_rsvd;
  assign unused_rsvd = fld.rsvd;

  always_comb begin
    ctrl_o         = '0;
    ctrl_o.t_src   = TS_KEEP;
    ctrl_o.pc_src  = PS_INC;
    ctrl_o.op      = fld.op;
    if (insn_i[15]) begin
      ctrl_o.t_src = TS_LIT;
      ctrl_o.dd    = 2'b01;
      ctrl_o.ds_we = 1'b1;
    end else begin
      unique case (insn_i[14:13])
        2'b00: ctrl_o.pc_src = PS_TGT;
        2'b01: begin
          ctrl_o.pc_src = PS_CBR;
          ctrl_o.t_src  = TS_N;
          ctrl_o.dd     = 2'b11;
        end
        2'b10: begin
          ctrl_o.pc_src  = PS_TGT;
          ctrl_o.rd      = 2'b01;
          ctrl_o.rs_we   = 1'b1;
          ctrl_o.rs_link = 1'b1;
        end
        default: begin
          ctrl_o.t_src  = TS_ALU;
          ctrl_o.pc_src = fld.r2pc ? PS_RET : PS_INC;
          ctrl_o.dd     = fld.dd;
          ctrl_o.rd     = fld.rd;
          ctrl_o.ds_we  = fld.t2n;
          ctrl_o.rs_we  = fld.t2r;
          ctrl_o.st     = fld.st;
        end
      endcase
    end
  end

endmodule

// File: rtl/stack_cpu_alu.sv
module stack_cpu_alu
  import stack_cpu_pkg::*;
(
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] t_i,
  input  logic [XLEN-1:0] n_i,
  input  logic [XLEN-1:0] r_i,
  input  logic [XLEN-1:0] ld_i,
  input  logic [XLEN-1:0] depth_i,
  output logic [XLEN-1:0] res_o
);

  localparam int unsigned SHW = $clog2(XLEN);

  logic [SHW-1:0] sh;
  assign sh = t_i[SHW-1:0];

  always_comb begin
    unique case (op_i)
      OP_T:     res_o = t_i;
      OP_N:     res_o = n_i;
      OP_ADD:   res_o = t_i + n_i;
      OP_AND:   res_o = t_i & n_i;
      OP_OR:    res_o = t_i | n_i;
      OP_XOR:   res_o = t_i ^ n_i;
      OP_INV:   res_o = ~t_i;
      OP_EQ:    res_o = {XLEN{n_i == t_i}};
      OP_LTS:   res_o = {XLEN{$signed(n_i) < $signed(t_i)}};
      OP_SHR:   res_o = n_i >> sh;
      OP_DEC:   res_o = t_i - XLEN'(1);
      OP_R:     res_o = r_i;
      OP_LD:    res_o = ld_i;
      OP_SHL:   res_o = n_i << sh;
      OP_DEPTH: res_o = depth_i;
      default:  res_o = {XLEN{n_i < t_i}};
    endcase
  end

  always_comb begin
    if (op_i == OP_EQ || op_i == OP_LTS || op_i == OP_LTU)
      AST_CMP_MASK: assert (res_o == '0 || res_o == '1); // R8
  end

endmodule

// File: rtl/stack_cpu_lifo.sv
module stack_cpu_lifo #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       dlt_i,
  input  logic             we_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] top_o,
  output logic [AW-1:0]    ptr_o
);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    ptr_q, ptr_d;

  // power-of-two depth gives modulo wrap for free
  assign ptr_d = ptr_q + {{(AW-2){dlt_i[1]}}, dlt_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      ptr_q <= ptr_d;
      if (we_i) mem_q[ptr_d] <= wdata_i;
    end
  end

  assign top_o = mem_q[ptr_q];
  assign ptr_o = ptr_q;

  AST_TOP_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> top_o == $past(wdata_i)); // R6

endmodule

// File: rtl/stack_cpu.sv
module stack_cpu
  import stack_cpu_pkg::*;
#(
  parameter int unsigned DS_DEPTH = 32,
  parameter int unsigned RS_DEPTH = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PCW-1:0]  pc_o,
  input  logic [XLEN-1:0] insn_i,
  output logic [PCW-1:0]  addr_o,
  output logic [XLEN-1:0] wdata_o,
  output logic            mem_we_o,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic            io_we_o,
  input  logic [XLEN-1:0] io_rdata_i,
  output logic [XLEN-1:0] tos_o,
  output logic [XLEN-1:0] nos_o,
  output logic [XLEN-1:0] rtos_o
);

  localparam int unsigned DAW   = $clog2(DS_DEPTH);
  localparam int unsigned RAW   = $clog2(RS_DEPTH);
  localparam int unsigned HALF  = XLEN / 2;
  localparam int unsigned IOBIT = PCW;

  ctrl_t           ctrl;
  logic [PCW-1:0]  pc_q, pc_d, pc_inc;
  logic [XLEN-1:0] t_q, t_d;
  logic [XLEN-1:0] n, r, alu_res, ld_data, depth, rs_wdata;
  logic [DAW-1:0]  dsp;
  logic [RAW-1:0]  rsp;
  logic            io_sel;

  stack_cpu_decode u_dec (
    .insn_i (insn_i),
    .ctrl_o (ctrl)
  );

  stack_cpu_lifo #(.WIDTH(XLEN), .DEPTH(DS_DEPTH)) u_dstk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dlt_i   (ctrl.dd),
    .we_i    (ctrl.ds_we),
    .wdata_i (t_q),
    .top_o   (n),
    .ptr_o   (dsp)
  );

  assign pc_inc   = pc_q + PCW'(1);
  assign rs_wdata = ctrl.rs_link ? XLEN'(pc_inc) : t_q;

  stack_cpu_lifo #(.WIDTH(XLEN), .DEPTH(RS_DEPTH)) u_rstk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dlt_i   (ctrl.rd),
    .we_i    (ctrl.rs_we),
    .wdata_i (rs_wdata),
    .top_o   (r),
    .ptr_o   (rsp)
  );

  assign io_sel  = t_q[IOBIT];
  assign ld_data = io_sel ? io_rdata_i : mem_rdata_i;
  assign depth   = {HALF'(rsp), HALF'(dsp)};

  stack_cpu_alu u_alu (
    .op_i    (ctrl.op),
    .t_i     (t_q),
    .n_i     (n),
    .r_i     (r),
    .ld_i    (ld_data),
    .depth_i (depth),
    .res_o   (alu_res)
  );

  always_comb begin
    unique case (ctrl.t_src)
      TS_LIT:  t_d = {1'b0, insn_i[XLEN-2:0]};
      TS_N:    t_d = n;
      TS_ALU:  t_d = alu_res;
      default: t_d = t_q;
    endcase
    unique case (ctrl.pc_src)
      PS_TGT:  pc_d = insn_i[PCW-1:0];
      PS_CBR:  pc_d = (t_q == '0) ? insn_i[PCW-1:0] : pc_inc;
      PS_RET:  pc_d = r[PCW-1:0];
      default: pc_d = pc_inc;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      t_q  <= '0;
    end else begin
      pc_q <= pc_d;
      t_q  <= t_d;
    end
  end

  assign pc_o     = pc_q;
  assign addr_o   = t_q[PCW-1:0];
  assign wdata_o  = n;
  assign mem_we_o = ctrl.st & ~io_sel;
  assign io_we_o  = ctrl.st & io_sel;
  assign tos_o    = t_q;
  assign nos_o    = n;
  assign rtos_o   = r;

  AST_LIT_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_i[15] |=> (tos_o == {1'b0, $past(insn_i[14:0])}) && (nos_o == $past(tos_o))); // R2

  AST_JMP_TGT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_i[15:13] == 3'b000) |=> pc_o == $past(insn_i[PCW-1:0])); // R3

  AST_CBR_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_i[15:13] == 3'b001) |=>
      pc_o == (($past(tos_o) == '0) ? $past(insn_i[PCW-1:0]) : $past(pc_o) + PCW'(1))); // R4

  AST_CALL_LINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_i[15:13] == 3'b010) |=>
      (rtos_o == XLEN'($past(pc_o) + PCW'(1))) && (pc_o == $past(insn_i[PCW-1:0]))); // R5

endmodule

// File: tb/stack_cpu_tb.sv
module stack_cpu_tb;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [12:0] pc_o, addr_o;
  logic [15:0] insn_i, wdata_o, mem_rdata_i, io_rdata_i, tos_o, nos_o, rtos_o;
  logic        mem_we_o, io_we_o;

  logic [15:0] prog [256];
  logic [15:0] ram  [256];
  int          io_cnt;
  logic [12:0] io_addr;
  logic [15:0] io_data;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2 clk_i = ~clk_i;

  assign insn_i      = prog[pc_o[7:0]];
  assign mem_rdata_i = ram[addr_o[7:0]];
  assign io_rdata_i  = 16'hBEEF;

  stack_cpu u_dut (
    .clk_i, .rst_ni, .pc_o, .insn_i, .addr_o, .wdata_o, .mem_we_o,
    .mem_rdata_i, .io_we_o, .io_rdata_i, .tos_o, .nos_o, .rtos_o
  );

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int i = 0; i < 256; i++) ram[i] <= 16'h0;
      io_cnt <= 0;
    end else begin
      if (mem_we_o) ram[addr_o[7:0]] <= wdata_o;
      if (io_we_o) begin
        io_cnt  <= io_cnt + 1;
        io_addr <= addr_o;
        io_data <= wdata_o;
      end
    end
  end

  function automatic logic [15:0] lit(input logic [14:0] v);
    return {1'b1, v};
  endfunction
  function automatic logic [15:0] jmp(input logic [12:0] a);
    return {3'b000, a};
  endfunction
  function automatic logic [15:0] cbr(input logic [12:0] a);
    return {3'b001, a};
  endfunction
  function automatic logic [15:0] cal(input logic [12:0] a);
    return {3'b010, a};
  endfunction
  function automatic logic [15:0] alu(input logic [3:0] op, input logic r2pc,
      input logic t2n, input logic t2r, input logic st,
      input logic [1:0] rd, input logic [1:0] dd);
    return {3'b011, r2pc, op, t2n, t2r, st, 1'b0, rd, dd};
  endfunction

  function automatic logic [15:0] exp_op(input logic [3:0] op, input logic [15:0] n,
      input logic [15:0] t);
    case (op)
      4'd0:  return t;
      4'd1:  return n;
      4'd2:  return n + t;
      4'd3:  return n & t;
      4'd4:  return n | t;
      4'd5:  return n ^ t;
      4'd6:  return ~t;
      4'd7:  return (n == t) ? 16'hFFFF : 16'h0;
      4'd8:  return ($signed(n) < $signed(t)) ? 16'hFFFF : 16'h0;
      4'd9:  return n >> t[3:0];
      4'd10: return t - 16'd1;
      4'd13: return n << t[3:0];
      4'd15: return (n < t) ? 16'hFFFF : 16'h0;
      default: return 16'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) prog[i] = 16'h0000;
  endtask

  task automatic run(input int cycles);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (cycles) @(negedge clk_i);
  endtask

  task automatic t_reset();
    clear_prog();
    prog[0] = alu(4'd14, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 2'b01);
    prog[1] = jmp(13'd1);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R1 pc in reset", {3'b0, pc_o}, 16'h0);
    check("R1 tos in reset", tos_o, 16'h0);
    check("R1 rtos in reset", rtos_o, 16'h0);
    rst_ni = 1'b1;
    repeat (10) @(negedge clk_i);
    check("R1 depth after reset", tos_o, 16'h0000);
  endtask

  task automatic t_lit();
    clear_prog();
    prog[0] = lit(15'h7FFF);
    prog[1] = lit(15'h1234);
    prog[2] = jmp(13'd2);
    run(10);
    check("R2 lit tos", tos_o, 16'h1234);
    check("R2 lit nos zero-ext", nos_o, 16'h7FFF);
  endtask

  task automatic t_binop(input logic [3:0] op, input logic [14:0] a, input logic [14:0] b);
    clear_prog();
    prog[0] = lit(a);
    prog[1] = lit(b);
    prog[2] = alu(op, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b11);
    prog[3] = jmp(13'd3);
    run(12);
    check($sformatf("R7/R9 op %0d a %h b %h", op, a, b), tos_o,
          exp_op(op, {1'b0, a}, {1'b0, b}));
  endtask

  task automatic t_signed();
    clear_prog();
    prog[0] = lit(15'd0);
    prog[1] = alu(4'd6, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00);
    prog[2] = lit(15'd1);
    prog[3] = alu(4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b11);
    prog[4] = jmp(13'd4);
    run(12);
    check("R8 signed -1<1", tos_o, 16'hFFFF);
    prog[3] = alu(4'd15, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b11);
    run(12);
    check("R8 unsigned FFFF<1", tos_o, 16'h0000);
  endtask

  task automatic t_jump();
    clear_prog();
    prog[0] = jmp(13'd5);
    prog[1] = lit(15'h0001);
    prog[5] = lit(15'h0022);
    prog[6] = jmp(13'd6);
    run(10);
    check("R3 jump target", tos_o, 16'h0022);
    check("R3 jump no push", nos_o, 16'h0000);
  endtask

  task automatic t_cbr(input logic [14:0] v, input logic [15:0] exp);
    clear_prog();
    prog[0] = lit(v);
    prog[1] = cbr(13'd4);
    prog[2] = lit(15'h0011);
    prog[3] = jmp(13'd3);
    prog[4] = lit(15'h0022);
    prog[5] = jmp(13'd5);
    run(12);
    check($sformatf("R4 cbr on %h", v), tos_o, exp);
    check("R4 cbr popped", nos_o, 16'h0000);
  endtask

  task automatic t_call();
    clear_prog();
    prog[0] = cal(13'd4);
    prog[1] = lit(15'h0033);
    prog[2] = jmp(13'd2);
    prog[4] = jmp(13'd4);
    run(10);
    check("R5 link address", rtos_o, 16'h0001);
    check("R5 call target", {3'b0, pc_o}, 16'h0004);
    prog[4] = alu(4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 2'b00);
    run(12);
    check("R11 returned", tos_o, 16'h0033);
    check("R11 return popped", rtos_o, 16'h0000);
  endtask

  task automatic t_rstack();
    clear_prog();
    prog[0] = lit(15'h0044);
    prog[1] = alu(4'd1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, 2'b11);
    prog[2] = jmp(13'd2);
    run(10);
    check("R6 t2r rtos", rtos_o, 16'h0044);
    check("R6 drop tos", tos_o, 16'h0000);
    prog[2] = alu(4'd11, 1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 2'b01);
    prog[3] = jmp(13'd3);
    run(10);
    check("R7 R op", tos_o, 16'h0044);
  endtask

  task automatic t_store();
    clear_prog();
    prog[0] = lit(15'h0ABC);
    prog[1] = lit(15'h0010);
    prog[2] = alu(4'd1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 2'b11);
    prog[3] = alu(4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b11);
    prog[4] = lit(15'h0010);
    prog[5] = alu(4'd12, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00);
    prog[6] = jmp(13'd6);
    run(14);
    check("R10 ram written", ram[8'h10], 16'h0ABC);
    check("R10 load ram", tos_o, 16'h0ABC);
    check("R10 no io strobe", 16'(io_cnt), 16'd0);
  endtask

  task automatic t_io();
    clear_prog();
    prog[0] = lit(15'h0055);
    prog[1] = lit(15'h2003);
    prog[2] = alu(4'd1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 2'b11);
    prog[3] = lit(15'h2000);
    prog[4] = alu(4'd12, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00);
    prog[5] = jmp(13'd5);
    run(14);
    check("R10 io strobe once", 16'(io_cnt), 16'd1);
    check("R10 io addr", {3'b0, io_addr}, 16'h0003);
    check("R10 io data", io_data, 16'h0055);
    check("R10 io store skips ram", ram[8'h03], 16'h0000);
    check("R10 io load", tos_o, 16'hBEEF);
  endtask

  task automatic t_wrap();
    clear_prog();
    for (int i = 0; i < 32; i++) prog[i] = lit(15'(i + 1));
    prog[32] = alu(4'd14, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 2'b01);
    prog[33] = jmp(13'd33);
    run(44);
    check("R12 overflow depth", tos_o, 16'h0000);
    check("R12 overflow nos", nos_o, 16'd32);
    clear_prog();
    prog[0] = alu(4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b11);
    prog[1] = alu(4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 2'b00);
    prog[2] = alu(4'd14, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 2'b01);
    prog[3] = jmp(13'd3);
    run(10);
    check("R12 underflow depth", tos_o, 16'h1F1F);
  endtask

  initial begin
    t_reset();
    t_lit();
    for (int op = 0; op < 16; op++) begin
      if (op != 11 && op != 12 && op != 14) begin
        t_binop(4'(op), 15'h0005, 15'h0003);
        t_binop(4'(op), 15'h00F3, 15'h0004);
      end
    end
    t_binop(4'd7, 15'h1234, 15'h1234);
    t_binop(4'd15, 15'h0003, 15'h0005);
    t_signed();
    t_jump();
    t_cbr(15'h0000, 16'h0022);
    t_cbr(15'h0007, 16'h0011);
    t_call();
    t_rstack();
    t_store();
    t_io();
    t_wrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule